// File: doc/BRIEF.md
# Buffered SPI Port on a Byte Register Bus

This block is a full-duplex SPI engine that moves one byte per transfer. A small CPU reaches it over an 8-bit register bus. Writing the transmit address queues a byte in a two-entry transmit FIFO. Reading the receive address returns the oldest received byte and removes it from a two-entry receive FIFO. Because of these FIFOs, software can queue the next byte, and collect the previous one, while a byte is still on the wire.

The port runs either as bus master or as slave. As master it produces the serial clock from the system clock through a power-of-two divider. As slave it follows an external clock while the select pin is low. Clock polarity and phase are programmable, and data is sent MSB first. A status register records events and clears when 1 is written to a bit. An interrupt line reports the status bits that are enabled. An external select input can hand the pins to an I2C engine; while it does, the SPI side stops driving them.

Top module: `spi_sfr_port`

## Requirements
- R1: After reset, config register 1 (0xE8) reads 0x10, and config register 2 (0xE9), status (0xEA) and the receive register (0x9B) read 0. `irq` is low and `sclk_o` is low.
- R2: In master mode, each transfer shifts 8 bits out on `sdo`, MSB first. On the same edges it shifts 8 bits in from `sdi`. With `sdo` looped back to `sdi`, the received byte equals the sent byte.
- R3: Writing 0x9A queues a byte in a 2-entry transmit FIFO. Two queued bytes are sent back to back, in the order written.
- R4: Reading 0x9B returns the oldest unread received byte and removes it. Reading it while the receive FIFO is empty returns 0.
- R5: A write to 0x9A while the transmit FIFO holds 2 bytes drops that byte and sets status bit 3.
- R6: A byte that completes while 2 received bytes are still unread is dropped and sets status bit 4.
- R7: Config register 1 bit 4 = 1 selects master. In master mode the serial clock half-period is 2^k system clocks, where k = config register 1 bits [2:0].
- R8: Config register 2 bit 1 sets clock polarity, and `sclk_o` idles at that level. Config register 2 bit 0 sets phase: 0 samples on the leading edge, 1 samples on the trailing edge.
- R9: With config register 1 bit 4 = 0 (slave), while `ss_n` is low, the block shifts on `sclk_i`. It sends the head of the transmit FIFO (0x00 if the FIFO is empty) and stores the received byte.
- R10: In slave mode, if `ss_n` rises before 8 bits have arrived, the partial byte is discarded. No status bit is set, and the next byte starts counting from bit 0.
- R11: Status bits are set by events and cleared by writing 1 to them. Bit 0 marks a finished byte. Bit 1 marks the transmit FIFO being emptied by a transfer start. Bit 2 marks a byte stored in the receive FIFO.
- R12: `irq` is high when any status bit [4:0] is set and its enable is set. The enables sit in config register 2 bits [7:3], with status bit n enabled by bit n+3.
- R13: While `i2c_sel` is high, `sclk_oe` and `sdo_oe` are low and no transfer starts. Writes still fill the transmit FIFO, and transfers resume when `i2c_sel` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| sfr_addr | input | 8 | Register address |
| sfr_wdata | input | 8 | Register write data |
| sfr_wr | input | 1 | Write strobe |
| sfr_rd | input | 1 | Read strobe (pops the receive FIFO at 0x9B) |
| sfr_rdata | output | 8 | Register read data, valid in the same cycle as the strobe |
| i2c_sel | input | 1 | High: the pins belong to the I2C function |
| sclk_i | input | 1 | Serial clock in (slave) |
| sclk_o | output | 1 | Serial clock out (master) |
| sclk_oe | output | 1 | Serial clock output enable |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out |
| sdo_oe | output | 1 | Serial data output enable |
| ss_n | input | 1 | Slave select, active low |
| irq | output | 1 | Interrupt |

## Verification
A bit counter that is off by one shows up at the ports within one byte. Every byte seen on `sdo` is then misaligned against the queued values, and the loopback read of 0x9B comes back shifted. A FIFO pointer or count error shows up at the next read of 0x9B or the next overflow flag, so each FIFO is pushed to exactly full and one beyond. A clock-state fault appears at once as a wrong idle level after a mode change, or as a wrong half-period between two clock edges.

// File: rtl/spi_sfr_port.sv
module spi_sfr_port #(
  parameter int FIFO_DEPTH = 2,
  parameter int DIV_BITS = 3,
  parameter logic [7:0] A_TX = 8'h9A,
  parameter logic [7:0] A_RX = 8'h9B,
  parameter logic [7:0] A_CFG1 = 8'hE8,
  parameter logic [7:0] A_CFG2 = 8'hE9,
  parameter logic [7:0] A_STAT = 8'hEA
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] sfr_addr,
  input  logic [7:0] sfr_wdata,
  input  logic       sfr_wr,
  input  logic       sfr_rd,
  output logic [7:0] sfr_rdata,
  input  logic       i2c_sel,
  input  logic       sclk_i,
  output logic       sclk_o,
  output logic       sclk_oe,
  input  logic       sdi,
  output logic       sdo,
  output logic       sdo_oe,
  input  logic       ss_n,
  output logic       irq
);
  localparam int PW = (FIFO_DEPTH > 1) ? $clog2(FIFO_DEPTH) : 1;
  localparam int CW = $clog2(FIFO_DEPTH + 1);
  localparam int CNT_W = (1 << DIV_BITS) - 1;

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(FIFO_DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  logic [7:0] cfg1, cfg2;
  logic [4:0] stat;
  logic [7:0] tx_mem [FIFO_DEPTH];
  logic [7:0] rx_mem [FIFO_DEPTH];
  logic [PW-1:0] tx_wp, tx_rp, rx_wp, rx_rp;
  logic [CW-1:0] tx_cnt, rx_cnt;
  logic [1:0] ss_sy, ck_sy;
  logic ck_q, busy, lvl;
  logic [3:0] e;
  logic [7:0] sh, rs;
  logic [CNT_W-1:0] div_cnt;

  wire wr_tx   = sfr_wr && sfr_addr == A_TX;
  wire rd_rx   = sfr_rd && sfr_addr == A_RX;
  wire tx_full = tx_cnt == CW'(FIFO_DEPTH);
  wire rx_full = rx_cnt == CW'(FIFO_DEPTH);
  wire tx_nemp = tx_cnt != '0;
  wire rx_nemp = rx_cnt != '0;
  wire cpha = cfg2[0];
  wire cpol = cfg2[1];
  wire master = cfg1[4] && !i2c_sel;
  wire ss_act = !cfg1[4] && !i2c_sel && !ss_sy[1];
  wire run = cfg1[4] ? !i2c_sel : ss_act;
  wire [CNT_W-1:0] half_m1 = CNT_W'((32'd1 << cfg1[DIV_BITS-1:0]) - 32'd1);

  wire start = !busy && (master ? tx_nemp : ss_act);
  wire tick  = busy && run && (master ? div_cnt == half_m1 : ck_sy[1] != ck_q);
  wire abort = busy && !run;
  wire last  = tick && e == 4'd15;
  wire smp   = e[0] == cpha;
  wire [7:0] rx_byte = cpha ? {rs[6:0], sdi} : rs;

  wire tx_push = wr_tx && !tx_full;
  wire tx_pop  = start && tx_nemp;
  wire rx_push = last && !rx_full;
  wire rx_pop  = rd_rx && rx_nemp;
  wire [4:0] stat_set = {last && rx_full, wr_tx && tx_full, rx_push,
                         tx_pop && tx_cnt == CW'(1) && !tx_push, last};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ss_sy <= 2'b11; ck_sy <= 2'b00; ck_q <= 1'b0;
    end else begin
      ss_sy <= {ss_sy[0], ss_n}; ck_sy <= {ck_sy[0], sclk_i}; ck_q <= ck_sy[1];
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      busy <= 1'b0; e <= '0; div_cnt <= '0; lvl <= 1'b0; sh <= '0; rs <= '0;
    end else if (start) begin
      busy <= 1'b1; e <= '0; div_cnt <= '0; lvl <= 1'b0; rs <= '0;
      sh <= tx_nemp ? tx_mem[tx_rp] : 8'h00;
    end else if (abort) begin
      busy <= 1'b0; e <= '0; lvl <= 1'b0;
    end else if (busy) begin
      div_cnt <= tick ? '0 : div_cnt + 1'b1;
      if (tick) begin
        lvl <= ~lvl;
        e <= e + 4'd1;
        if (smp) rs <= {rs[6:0], sdi};
        else if (!(cpha && e == 4'd0)) sh <= {sh[6:0], 1'b0};
        if (e == 4'd15) busy <= 1'b0;
      end
    end

  always_ff @(posedge clk) begin
    if (tx_push) tx_mem[tx_wp] <= sfr_wdata;
    if (rx_push) rx_mem[rx_wp] <= rx_byte;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      tx_wp <= '0; tx_rp <= '0; tx_cnt <= '0;
      rx_wp <= '0; rx_rp <= '0; rx_cnt <= '0;
    end else begin
      if (tx_push) tx_wp <= nxt(tx_wp);
      if (tx_pop)  tx_rp <= nxt(tx_rp);
      tx_cnt <= tx_cnt + CW'(tx_push) - CW'(tx_pop);
      if (rx_push) rx_wp <= nxt(rx_wp);
      if (rx_pop)  rx_rp <= nxt(rx_rp);
      rx_cnt <= rx_cnt + CW'(rx_push) - CW'(rx_pop);
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cfg1 <= 8'h10; cfg2 <= 8'h00; stat <= '0;
    end else begin
      if (sfr_wr && sfr_addr == A_CFG1) cfg1 <= sfr_wdata;
      if (sfr_wr && sfr_addr == A_CFG2) cfg2 <= sfr_wdata;
      stat <= (stat & ~((sfr_wr && sfr_addr == A_STAT) ? sfr_wdata[4:0] : 5'd0)) | stat_set;
    end

  always_comb
    case (sfr_addr)
      A_RX:    sfr_rdata = rx_nemp ? rx_mem[rx_rp] : 8'h00;
      A_CFG1:  sfr_rdata = cfg1;
      A_CFG2:  sfr_rdata = cfg2;
      A_STAT:  sfr_rdata = {3'b000, stat};
      default: sfr_rdata = 8'h00;
    endcase

  assign sclk_oe = master;
  assign sclk_o  = master && (lvl ^ cpol);
  assign sdo_oe  = master || ss_act;
  assign sdo     = sdo_oe && sh[7];
  assign irq     = |(stat & cfg2[7:3]);

  a_r8_idle_level: assert property (@(posedge clk) disable iff (!rst_n)
    (master && !busy) |-> sclk_o == cpol);
  a_r5_tx_overflow_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_tx && tx_full) |=> stat[3]);
  a_r6_rx_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (last && rx_full && !rx_pop) |=> (rx_full && $stable(rx_wp)));
  a_r10_slave_abort: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !cfg1[4] && !i2c_sel && ss_sy[1]) |=> (!busy && e == 4'd0));
  a_r13_pins_released: assert property (@(posedge clk) disable iff (!rst_n)
    i2c_sel |=> !busy);
  a_r3_fifo_bounds: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_cnt <= CW'(FIFO_DEPTH)) && (rx_cnt <= CW'(FIFO_DEPTH)));
endmodule

// File: tb/spi_sfr_port_tb.sv
module spi_sfr_port_tb_top;
  logic clk = 0, rst_n = 0;
  logic [7:0] sfr_addr = 0, sfr_wdata = 0, sfr_rdata;
  logic sfr_wr = 0, sfr_rd = 0, i2c_sel = 0, s_sclk = 0, s_sdi = 0, ss_n = 1, loop = 1;
  logic sclk_o, sclk_oe, sdo, sdo_oe, irq;
  wire sdi = loop ? sdo : s_sdi;
  int checks = 0, errors = 0;
  logic [7:0] exp_q [$];
  logic mon_en = 0, cur_cpol = 0, cur_cpha = 0;
  logic [7:0] r;

  always #4 clk = ~clk;

  spi_sfr_port dut_i (.clk(clk), .rst_n(rst_n), .sfr_addr(sfr_addr), .sfr_wdata(sfr_wdata),
    .sfr_wr(sfr_wr), .sfr_rd(sfr_rd), .sfr_rdata(sfr_rdata), .i2c_sel(i2c_sel),
    .sclk_i(s_sclk), .sclk_o(sclk_o), .sclk_oe(sclk_oe), .sdi(sdi), .sdo(sdo),
    .sdo_oe(sdo_oe), .ss_n(ss_n), .irq(irq));

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); sfr_addr = a; sfr_wdata = d; sfr_wr = 1;
    @(negedge clk); sfr_wr = 0; sfr_addr = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk); sfr_addr = a; sfr_rd = 1; #1 d = sfr_rdata;
    @(negedge clk); sfr_rd = 0; sfr_addr = 0;
  endtask

  task automatic send(input logic [7:0] b, input bit expect_it);
    wr(8'h9A, b);
    if (expect_it) exp_q.push_back(b);
  endtask

  task automatic set_mode(input logic [7:0] c1, input logic pol, input logic pha);
    mon_en = 0;
    wr(8'hE8, c1);
    wr(8'hE9, {6'b0, pol, pha});
    cur_cpol = pol; cur_cpha = pha;
    @(negedge clk); mon_en = 1;
  endtask

  task automatic drain(input string req);
    repeat (300) @(negedge clk);
    chk(req, 8'(exp_q.size()), 8'd0);
  endtask

  // monitor: collects sdo on the sampling edge and compares with the queue
  logic mprev = 0; logic [7:0] mbyte = 0; int mn = 0;
  always @(negedge clk) begin
    if (!mon_en || !sclk_oe) begin
      mprev = cur_cpol; mn = 0;
    end else if (sclk_o != mprev) begin
      if ((mprev == cur_cpol) ^ cur_cpha) begin
        mbyte = {mbyte[6:0], sdo}; mn++;
        if (mn == 8) begin
          mn = 0;
          if (exp_q.size() == 0) chk("R2 unexpected byte", mbyte, 8'hxx);
          else chk("R2/R3 serial byte", mbyte, exp_q.pop_front());
        end
      end
      mprev = sclk_o;
    end
  end

  task automatic slave_xfer(input logic [7:0] tx, input int nbits, output logic [7:0] got);
    got = 0;
    ss_n = 0;
    repeat (10) @(negedge clk);
    for (int i = 7; i > 7 - nbits; i--) begin
      s_sdi = tx[i];
      repeat (10) @(negedge clk);
      got = {got[6:0], sdo};
      s_sclk = 1;
      repeat (10) @(negedge clk);
      s_sclk = 0;
    end
    repeat (10) @(negedge clk);
    ss_n = 1;
    repeat (10) @(negedge clk);
  endtask

  task automatic finish_sim();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_sim();
  end

  initial begin
    int t;
    repeat (3) @(negedge clk); rst_n = 1;
    // R1 reset state
    rd(8'hE8, r); chk("R1 cfg1", r, 8'h10);
    rd(8'hE9, r); chk("R1 cfg2", r, 8'h00);
    rd(8'hEA, r); chk("R1 stat", r, 8'h00);
    rd(8'h9B, r); chk("R1 rx", r, 8'h00);
    chk("R1 irq", 8'(irq), 8'd0);
    chk("R1 sclk", 8'(sclk_o), 8'd0);

    // R2 R3 back-to-back master loopback, mode 0, k=1
    set_mode(8'h11, 0, 0);
    send(8'hA5, 1); send(8'h3C, 1);
    drain("R3 both bytes sent");
    rd(8'hEA, r); chk("R11 status after two bytes", r, 8'h07);
    chk("R12 irq disabled", 8'(irq), 8'd0);
    wr(8'hE9, 8'h20);
    chk("R12 irq enabled rx-avail", 8'(irq), 8'd1);
    rd(8'h9B, r); chk("R4 first pop", r, 8'hA5);
    rd(8'h9B, r); chk("R4 second pop", r, 8'h3C);
    rd(8'h9B, r); chk("R4 empty read", r, 8'h00);
    wr(8'hEA, 8'h01);
    rd(8'hEA, r); chk("R11 clear bit0 only", r, 8'h06);
    wr(8'hEA, 8'h1E);
    rd(8'hEA, r); chk("R11 all cleared", r, 8'h00);
    chk("R12 irq low after clear", 8'(irq), 8'd0);
    wr(8'hE9, 8'h00);

    // R13 R5 pins handed to I2C; third write overflows
    i2c_sel = 1;
    @(negedge clk);
    chk("R13 sclk_oe", 8'(sclk_oe), 8'd0);
    chk("R13 sdo_oe", 8'(sdo_oe), 8'd0);
    send(8'h11, 1); send(8'h22, 1); send(8'h33, 0);
    repeat (50) @(negedge clk);
    rd(8'hEA, r); chk("R5/R13 overflow only, no transfer", r, 8'h08);
    i2c_sel = 0;
    drain("R13 resumes after release");
    rd(8'h9B, r); chk("R5 first kept", r, 8'h11);
    rd(8'h9B, r); chk("R5 second kept", r, 8'h22);
    rd(8'h9B, r); chk("R5 dropped byte absent", r, 8'h00);
    wr(8'hEA, 8'h1F);

    // R6 receive overflow
    send(8'h44, 1); send(8'h55, 1);
    repeat (10) @(negedge clk);
    send(8'h66, 1);
    drain("R6 three sent");
    rd(8'hEA, r); chk("R6 rx overflow status", r, 8'h17);
    rd(8'h9B, r); chk("R6 oldest", r, 8'h44);
    rd(8'h9B, r); chk("R6 second", r, 8'h55);
    rd(8'h9B, r); chk("R6 third dropped", r, 8'h00);
    wr(8'hEA, 8'h1F);

    // R7 R8 other modes, k=2
    for (int m = 0; m < 3; m++) begin
      logic pol, pha;
      logic [7:0] b;
      pol = (m != 1); pha = (m != 2);
      b = 8'h96 ^ 8'(m * 37);
      set_mode(8'h12, pol, pha);
      chk("R8 idle level", 8'(sclk_o), 8'(pol));
      send(b, 1);
      if (m == 0) begin
        t = 0;
        while (sclk_o == pol && t < 100) begin @(negedge clk); t++; end
        t = 0;
        while (sclk_o != pol && t < 100) begin @(negedge clk); t++; end
        chk("R7 half period k=2", 8'(t), 8'd4);
      end
      drain("R8 mode byte");
      rd(8'h9B, r); chk("R2/R8 loopback", r, b);
      wr(8'hEA, 8'h1F);
    end

    // R9 slave transfer
    mon_en = 0; loop = 0;
    wr(8'hE9, 8'h00); cur_cpol = 0; cur_cpha = 0;
    wr(8'hE8, 8'h00);
    send(8'h5A, 0);
    slave_xfer(8'hC3, 8, r);
    chk("R9 slave sdo byte", r, 8'h5A);
    rd(8'h9B, r); chk("R9 slave received", r, 8'hC3);
    rd(8'hEA, r); chk("R9/R11 slave status", r, 8'h07);
    wr(8'hEA, 8'h1F);

    // R10 slave abort
    slave_xfer(8'hFF, 3, r);
    rd(8'hEA, r); chk("R10 no status after abort", r, 8'h00);
    rd(8'h9B, r); chk("R10 nothing stored", r, 8'h00);
    slave_xfer(8'h81, 8, r);
    chk("R9 empty fifo sends zero", r, 8'h00);
    rd(8'h9B, r); chk("R10 clean byte after abort", r, 8'h81);

    finish_sim();
  end
endmodule